// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Controller

This block gathers three interrupt events: periodic, alarm and update-ended. Each event is latched into a flag bit of a status byte. Software polls the flags by reading that byte, and a read clears them. Each flag has its own enable input. When any flag is set and its enable is also set, the active-low interrupt line is pulled low. The event generators and the register address decoding sit outside the block. The decoder raises `rd_cyc_i` for the whole time the status byte is being read.

The read path works as a two-state machine.
- **IDLE**: the status byte shows the live flags, and events set their flags directly.
- **HOLD**: entered on the transition *IDLE→HOLD (read start)*. That transition fires on the first edge at which `rd_cyc_i` is high. At that edge the live byte is captured into a snapshot. While in HOLD the snapshot is driven out unchanged, the flags are frozen, and new events collect in per-source pending bits.
- **HOLD→IDLE (read end)**: fires on the first edge at which `rd_cyc_i` is low. That edge clears every flag and then loads the pending bits, together with any event present in that same cycle, into the flags.

The status byte has a fixed layout:

| Bit | Meaning | Source index |
|-----|---------|--------------|
| 7 | summary bit (interrupt line active) | — |
| 6 | periodic flag | `evt_i[2]` |
| 5 | alarm flag | `evt_i[1]` |
| 4 | update-ended flag | `evt_i[0]` |
| 3:0 | always zero | — |

Top module: `irqc_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no events, all flags are 0, `irq_n_o` is 1 and `rd_data_o` is 8'h00.
- R2: A one-cycle pulse on `evt_i[k]` outside a read sets its flag at the next clock edge whatever `en_i[k]` is. `evt_i[2]` sets bit 6, `evt_i[1]` sets bit 5 and `evt_i[0]` sets bit 4 of `rd_data_o`. Clearing an enable leaves its flag set.
- R3: `irq_n_o` is 0 exactly when some index k has both flag k and `en_i[k]` set. An enable change acts in the same cycle, with no clock edge needed.
- R4: Outside a read, bit 7 of `rd_data_o` is the inverse of `irq_n_o`. Bits 3:0 of `rd_data_o` always read 0.
- R5: From the edge that starts a read until `rd_cyc_i` falls, `rd_data_o` holds the byte that was live on the starting edge.
- R6: The edge at which `rd_cyc_i` is first seen low clears every flag that was read.
- R7: An event during a read changes neither the flags nor `irq_n_o` until the read ends. It then sets its flag.
- R8: An event in the cycle where `rd_cyc_i` is first low sets its flag after the clear, so it is not lost.
- R9: An event in the cycle where `rd_cyc_i` first rises is left out of the captured byte. It sets its flag when the read ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 3 | Event pulses: [2] periodic, [1] alarm, [0] update-ended |
| en_i | input | 3 | Interrupt enables, same indexing as `evt_i` |
| rd_cyc_i | input | 1 | High for the duration of a status-byte read |
| rd_data_o | output | 8 | Status byte (live, or the snapshot during a read) |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench aims events at the three awkward moments of a read: the cycle the read window opens, the middle of the window, and the cycle it closes.
- A design that samples the byte one edge late would show the opening event in the snapshot.
- A design that lets flags move during the window would fail the repeated stability sample. It would also assert the interrupt line early.
- A design that clears after merging would drop the closing event.

Turning an enable on and off over a flag that is already set checks that the interrupt line follows with no edge and that the flag survives.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC  = 3;
    localparam int DATA_W   = 8;
    localparam int FLAG_LSB = 4;
    localparam int SUM_BIT  = DATA_W - 1;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_HOLD = 1'b1
    } rd_state_e;

endpackage

// File: rtl/irqc_rd_fsm.sv
module irqc_rd_fsm
    import irqc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      rd_cyc_i,
    output rd_state_e state_o,
    output logic      capture_o,
    output logic      hold_o,
    output logic      commit_o
);

    rd_state_e st_q;
    rd_state_e st_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (rd_cyc_i)  st_d = RD_HOLD;
            RD_HOLD: if (!rd_cyc_i) st_d = RD_IDLE;
        endcase
    end

    always_comb begin
        capture_o = 1'b0;
        hold_o    = 1'b0;
        commit_o  = 1'b0;
        unique case (st_q)
            RD_IDLE: capture_o = rd_cyc_i;
            RD_HOLD: begin
                hold_o   = rd_cyc_i;
                commit_o = !rd_cyc_i;
            end
        endcase
    end

    assign state_o = st_q;

endmodule

// File: rtl/irqc_flag_cell.sv
module irqc_flag_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic capture_i,
    input  logic hold_i,
    input  logic commit_i,
    output logic flag_o
);

    logic flag_q;
    logic pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (commit_i) begin
            flag_q <= pend_q | evt_i;
            pend_q <= 1'b0;
        end else if (capture_i || hold_i) begin
            pend_q <= pend_q | evt_i;
        end else if (evt_i) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/irqc_irq_gen.sv
module irqc_irq_gen #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic         active_o,
    output logic         irq_n_o
);

    assign active_o = |(flags_i & en_i);
    assign irq_n_o  = ~active_o;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               rd_cyc_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_n_o
);

    rd_state_e          st;
    logic               capture;
    logic               hold;
    logic               commit;
    logic [NUM_SRC-1:0] flags;
    logic               active;
    logic [DATA_W-1:0]  live_byte;
    logic [DATA_W-1:0]  snap_q;

    irqc_rd_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_cyc_i  (rd_cyc_i),
        .state_o   (st),
        .capture_o (capture),
        .hold_o    (hold),
        .commit_o  (commit)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        irqc_flag_cell u_cell (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .evt_i     (evt_i[k]),
            .capture_i (capture),
            .hold_i    (hold),
            .commit_i  (commit),
            .flag_o    (flags[k])
        );
    end

    irqc_irq_gen #(.N(NUM_SRC)) u_irq (
        .flags_i  (flags),
        .en_i     (en_i),
        .active_o (active),
        .irq_n_o  (irq_n_o)
    );

    always_comb begin
        live_byte                        = '0;
        live_byte[SUM_BIT]               = active;
        live_byte[FLAG_LSB +: NUM_SRC]   = flags;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            snap_q <= '0;
        end else if (capture) begin
            snap_q <= live_byte;
        end
    end

    assign rd_data_o = (st == RD_HOLD) ? snap_q : live_byte;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               rd_cyc_i,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic               irq_n_o,
    input logic [NUM_SRC-1:0] flags,
    input rd_state_e          st
);

    // R2
    poll_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == RD_IDLE && !rd_cyc_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));

    // R4
    sum_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == RD_IDLE) |-> (rd_data_o[SUM_BIT] == !irq_n_o));

    // R4
    low_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[FLAG_LSB-1:0] == '0);

    // R5
    snap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_cyc_i && $past(rd_cyc_i)) |-> $stable(rd_data_o));

    // R7
    frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == RD_HOLD && rd_cyc_i) |=> ($stable(flags) && $stable(irq_n_o) || $changed(st)));

    // R8
    late_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == RD_HOLD && !rd_cyc_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));

endmodule

bind irqc_top irqc_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .rd_cyc_i  (rd_cyc_i),
    .rd_data_o (rd_data_o),
    .irq_n_o   (irq_n_o),
    .flags     (flags),
    .st        (st)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] evt;
    logic [2:0] en;
    logic       rd;
    logic [7:0] rd_data;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    logic mon_go = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mon_exp;
    string      mon_tag;

    always #4 clk = ~clk;

    irqc_top u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .evt_i     (evt),
        .en_i      (en),
        .rd_cyc_i  (rd),
        .rd_data_o (rd_data),
        .irq_n_o   (irq_n)
    );

    // monitor: pops expected snapshot bytes during read windows
    always @(negedge clk) begin
        if (mon_go) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            checks++;
            if (rd_data !== mon_exp) begin
                errors++;
                $display("FAIL %s rd_data=%h expected=%h", mon_tag, rd_data, mon_exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_byte(input string tag, input logic [7:0] exp);
        @(negedge clk);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s rd_data=%h expected=%h", tag, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        @(negedge clk);
        checks++;
        if (irq_n !== exp) begin
            errors++;
            $display("FAIL %s irq_n=%b expected=%b", tag, irq_n, exp);
        end
    endtask

    task automatic pulse(input logic [2:0] v);
        step();
        evt = v;
        step();
        evt = 3'b000;
    endtask

    // one read of the status byte; called just after a rising edge
    task automatic read_c(input logic [7:0] exp, input logic [2:0] ev_start,
                          input logic [2:0] ev_mid, input logic [2:0] ev_end,
                          input logic irq_mid, input int len);
        step();
        rd  = 1'b1;
        evt = ev_start;
        exp_q.push_back(exp);
        tag_q.push_back("R5 first sample");
        step();
        evt    = ev_mid;
        mon_go = 1'b1;
        step();
        evt    = 3'b000;
        mon_go = 1'b0;
        chk_irq("R7 irq during read", irq_mid);
        step();
        for (int i = 2; i < len; i++) step();
        exp_q.push_back(exp);
        tag_q.push_back("R5 last sample");
        mon_go = 1'b1;
        step();
        mon_go = 1'b0;
        rd     = 1'b0;
        evt    = ev_end;
        step();
        evt = 3'b000;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        evt   = 3'b000;
        en    = 3'b000;
        rd    = 1'b0;
        repeat (3) step();
        chk_irq("R1 irq in reset", 1'b1);
        step();
        rst_n = 1'b1;
        step();
        chk_byte("R1 byte after reset", 8'h00);
        chk_irq("R1 irq after reset", 1'b1);

        // R2: periodic flag set while disabled
        pulse(3'b100);
        chk_byte("R2 periodic polled", 8'h40);
        chk_irq("R2 no irq while disabled", 1'b1);

        // R3/R4: enabling over a set flag asserts at once
        step();
        en = 3'b100;
        chk_irq("R3 immediate assert", 1'b0);
        chk_byte("R4 summary bit", 8'hC0);

        // R5/R6/R7: read with alarm mid-window
        read_c(8'hC0, 3'b000, 3'b010, 3'b000, 1'b0, 4);
        chk_byte("R6 periodic cleared, R7 alarm deferred", 8'h20);
        chk_irq("R6 irq released", 1'b1);

        // R8: update event in the closing cycle
        read_c(8'h20, 3'b000, 3'b000, 3'b001, 1'b1, 3);
        chk_byte("R8 late event kept", 8'h10);

        // R3: enable on then off
        step();
        en = 3'b111;
        chk_byte("R3 enable all", 8'h90);
        chk_irq("R3 enable all irq", 1'b0);
        step();
        en = 3'b000;
        chk_irq("R3 disable releases", 1'b1);
        chk_byte("R2 flag kept after disable", 8'h10);

        // R6: all three set then read clean
        step();
        en = 3'b111;
        pulse(3'b111);
        chk_byte("R2 all flags", 8'hF0);
        read_c(8'hF0, 3'b000, 3'b000, 3'b000, 1'b0, 3);
        chk_byte("R6 all cleared", 8'h00);
        chk_irq("R6 irq high", 1'b1);

        // R7: enabled event mid-read must not assert irq in the window
        read_c(8'h00, 3'b000, 3'b100, 3'b000, 1'b1, 3);
        chk_byte("R7 applied after read", 8'hC0);
        chk_irq("R7 irq after read", 1'b0);

        // R9: event on the opening cycle is not in the snapshot
        read_c(8'hC0, 3'b010, 3'b000, 3'b000, 1'b0, 3);
        chk_byte("R9 opening event applied", 8'hA0);
        chk_irq("R9 irq", 1'b0);

        repeat (2) step();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule